// File: doc/BRIEF.md
# Bridge Abort and Timeout Monitor

This block sits beside a host-to-DSP access bridge and drives one abort interrupt line toward the host. Three fault sources feed the line. The first is an abort indication from the DSP side. The second is a timeout, raised when a request the bridge issued gets no acknowledge within a set number of cycles. The third is a detected burst access. The DSP-abort and timeout sources can each be masked through a control register. The burst source cannot be masked.

A sticky flag register records which source fired, and the interrupt stays high while any flag is set. Reading the flag register clears the flags. The first fault, or the first access mismatch reported by the bridge, copies the low 24 bits of the bridge address into a debug register. That register then holds its value until software clears the flags, so the first faulting address is kept for inspection.

Every pin is a plain control or status signal. No data moves through the block, so there is no valid/ready stream and no back-pressure. Register accesses take effect in a single cycle. Read data is combinational from the current state.

Top module: `abort_mon`

## Requirements
- R1: Control bit 3 enables the DSP-abort source and resets to 1. While it is 0, `dsp_abort` sets no flag and does not raise `irq_abort`. While it is 1, `dsp_abort` sets flag bit 0 at the next clock edge.
- R2: Control bit 1 enables the timeout and resets to 1. A request is sampled on the edge where `req_valid` is high, `req_ack` is low and no request is pending. If no acknowledge follows, flag bit 1 is set and `irq_abort` rises at the edge TO_CYCLES cycles after the request edge. While bit 1 is 0, the request waits without limit and raises nothing. Setting bit 1 again lets the overdue request fire at the next edge.
- R3: A high `burst_det` at a clock edge always sets flag bit 2, whatever the control register holds.
- R4: Control bit 0 selects frequency mode and resets to 0. It reads back as written. When it is 1, the timeout window is 2*TO_CYCLES cycles.
- R5: Register select 1 reads the flags in bits 2:0, with DSP abort in bit 0, timeout in bit 1 and burst in bit 2. The flags are sticky. A read of select 1 clears them at that edge, but a source firing on the same edge stays set. `irq_abort` is high exactly when a flag is set.
- R6: Register select 2 reads the debug address in bits 23:0, with bits 31:24 reading 0. The debug address resets to 0xFFFFFF.
- R7: When a flag is set or `acc_mismatch` is high while the debug address is not frozen, the debug address loads `bus_addr` and becomes frozen. A mismatch alone raises no interrupt. The debug address stays unchanged until a flag-register read unfreezes it.
- R8: An acknowledge ends a pending request and no timeout follows it.
- R9: Control bit 2 is reserved. It always reads 0 and writes to it have no effect.
- R10: After reset, select 0 reads 0x0000000A, the flags read 0 and `irq_abort` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 debug address |
| reg_wr | input | 1 | Write strobe (only the control register is writable) |
| reg_rd | input | 1 | Read strobe (a flag read clears the flags) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| req_valid | input | 1 | Bridge issues a request to the DSP |
| req_ack | input | 1 | DSP acknowledges the pending request |
| bus_addr | input | 24 | Low address bits of the current bridge access |
| acc_mismatch | input | 1 | Bridge reports an access mismatch |
| burst_det | input | 1 | Burst access detected |
| dsp_abort | input | 1 | Abort indication from the DSP side |
| irq_abort | output | 1 | Merged abort interrupt to the host |

## Verification
The bench walks a table of vectors. Each vector pairs a control value with DSP-abort and burst pulses that arrive alone or together. The table separates a masked source from an unmasked one, and it shows that the burst source ignores every control bit. Timeout runs are checked one cycle before and at the expected edge in both frequency modes, which pins the window length to the cycle. They also check that an acknowledge cancels the wait and that a disabled timeout waits without limit. The debug sequence places a second fault and a mismatch after the first capture to show the freeze. A fresh mismatch after the flag read shows the register is unfrozen again.

// File: rtl/abort_mon_pkg.sv
package abort_mon_pkg;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DBG   = 2'd2;

  // control bit positions (decoded by software, so fixed)
  localparam int CB_FREQ     = 0;
  localparam int CB_TO_EN    = 1;
  localparam int CB_RSVD     = 2;
  localparam int CB_ABORT_EN = 3;

  // flag bit positions
  localparam int NUM_SRC  = 3;
  localparam int FL_ABORT = 0;
  localparam int FL_TOUT  = 1;
  localparam int FL_BURST = 2;

  typedef struct packed {
    logic abort_en;
    logic to_en;
    logic hi_freq;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{abort_en: 1'b1, to_en: 1'b1, hi_freq: 1'b0};

endpackage

// File: rtl/abort_mon_ctrl.sv
module abort_mon_ctrl
  import abort_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] ctrl_word
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl_q.abort_en <= wdata[CB_ABORT_EN];
      ctrl_q.to_en    <= wdata[CB_TO_EN];
      ctrl_q.hi_freq  <= wdata[CB_FREQ];
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CB_ABORT_EN] = ctrl_q.abort_en;
    ctrl_word[CB_RSVD]     = 1'b0;
    ctrl_word[CB_TO_EN]    = ctrl_q.to_en;
    ctrl_word[CB_FREQ]     = ctrl_q.hi_freq;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/abort_mon_timer.sv
module abort_mon_timer #(
  parameter int TO_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_ack,
  input  logic to_en,
  input  logic hi_freq,
  output logic busy,
  output logic to_fire
);

  localparam int LIM_LO = TO_CYCLES;
  localparam int LIM_HI = 2 * TO_CYCLES;
  localparam int CNT_W  = $clog2(LIM_HI + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic             busy_q;
  logic             at_lim;

  assign lim_m1  = hi_freq ? CNT_W'(LIM_HI - 1) : CNT_W'(LIM_LO - 1);
  assign at_lim  = (cnt_q >= lim_m1);
  assign to_fire = busy_q & ~req_ack & at_lim & to_en;
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      cnt_q <= '0;
      if (req_valid && !req_ack) busy_q <= 1'b1;
    end else if (req_ack || to_fire) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!at_lim) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/abort_mon_flags.sv
module abort_mon_flags
  import abort_mon_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_src,
  input  logic               clr,
  input  logic               mismatch,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SRC-1:0] flags,
  output logic [ADDR_W-1:0]  dbg_addr,
  output logic               frozen
);

  logic [NUM_SRC-1:0] flag_q;
  logic [ADDR_W-1:0]  dbg_q;
  logic               frozen_q;
  logic               cap;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= (flag_q[i] & ~clr) | set_src[i];
    end
  end

  assign cap = (|set_src) | mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q    <= '1;
      frozen_q <= 1'b0;
    end else begin
      if (cap && (!frozen_q || clr)) dbg_q <= addr;
      if (clr)      frozen_q <= cap;
      else if (cap) frozen_q <= 1'b1;
    end
  end

  assign flags    = flag_q;
  assign dbg_addr = dbg_q;
  assign frozen   = frozen_q;

endmodule

// File: rtl/abort_mon.sv
module abort_mon
  import abort_mon_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 24,
  parameter int TO_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic              req_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              acc_mismatch,
  input  logic              burst_det,
  input  logic              dsp_abort,
  output logic              irq_abort
);

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  ctrl_word;
  logic               tmr_busy;
  logic               to_fire;
  logic [NUM_SRC-1:0] set_src;
  logic [NUM_SRC-1:0] flags_q;
  logic [ADDR_W-1:0]  dbg_q;
  logic               frozen_q;
  logic               rd_clr;
  logic               ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign rd_clr  = reg_rd && (reg_sel == SEL_FLAGS);

  abort_mon_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (reg_wdata),
    .ctrl     (ctrl_q),
    .ctrl_word(ctrl_word)
  );

  abort_mon_timer #(.TO_CYCLES(TO_CYCLES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ack  (req_ack),
    .to_en    (ctrl_q.to_en),
    .hi_freq  (ctrl_q.hi_freq),
    .busy     (tmr_busy),
    .to_fire  (to_fire)
  );

  always_comb begin
    set_src           = '0;
    set_src[FL_ABORT] = dsp_abort & ctrl_q.abort_en;
    set_src[FL_TOUT]  = to_fire;
    set_src[FL_BURST] = burst_det;
  end

  abort_mon_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_src (set_src),
    .clr     (rd_clr),
    .mismatch(acc_mismatch),
    .addr    (bus_addr),
    .flags   (flags_q),
    .dbg_addr(dbg_q),
    .frozen  (frozen_q)
  );

  assign irq_abort = |flags_q;

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL:  reg_rdata = ctrl_word;
      SEL_FLAGS: reg_rdata = DATA_W'(flags_q);
      SEL_DBG:   reg_rdata = DATA_W'(dbg_q);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/abort_mon_chk.sv
module abort_mon_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dsp_abort,
  input logic              burst_det,
  input logic              req_ack,
  input logic              irq_abort,
  input logic [2:0]        flags,
  input logic              abort_en,
  input logic              to_en,
  input logic              busy,
  input logic              to_fire,
  input logic              rd_clr,
  input logic              frozen,
  input logic [ADDR_W-1:0] dbg_addr
);

  AST_ABORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(dsp_abort && abort_en)); // R1

  AST_TIMEOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(to_en && busy)); // R2

  AST_BURST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_det |=> irq_abort); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !burst_det && !dsp_abort && !to_fire) |=> !irq_abort); // R5

  AST_DBG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_clr) |=> $stable(dbg_addr)); // R7

  AST_ACK_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_ack) |=> !busy); // R8

endmodule

bind abort_mon abort_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dsp_abort(dsp_abort),
  .burst_det(burst_det),
  .req_ack  (req_ack),
  .irq_abort(irq_abort),
  .flags    (flags_q),
  .abort_en (ctrl_q.abort_en),
  .to_en    (ctrl_q.to_en),
  .busy     (tmr_busy),
  .to_fire  (to_fire),
  .rd_clr   (rd_clr),
  .frozen   (frozen_q),
  .dbg_addr (dbg_q)
);

// File: tb/sim_abort_mon.sv
`timescale 1ns/1ps
module sim_abort_mon;

  localparam int TO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ack = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        acc_mismatch = 1'b0;
  logic        burst_det = 1'b0;
  logic        dsp_abort = 1'b0;
  logic        irq_abort;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  abort_mon #(.TO_CYCLES(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ack(req_ack), .bus_addr(bus_addr),
    .acc_mismatch(acc_mismatch), .burst_det(burst_det),
    .dsp_abort(dsp_abort), .irq_abort(irq_abort)
  );

  // {ctrl[3:0], dsp_abort, burst_det, expected flags[2:0]}
  localparam logic [8:0] VEC [8] = '{
    {4'h8, 1'b1, 1'b0, 3'b001},
    {4'h0, 1'b1, 1'b0, 3'b000},
    {4'h0, 1'b0, 1'b1, 3'b100},
    {4'h8, 1'b1, 1'b1, 3'b101},
    {4'h2, 1'b1, 1'b1, 3'b100},
    {4'hA, 1'b0, 1'b0, 3'b000},
    {4'h0, 1'b1, 1'b1, 3'b100},
    {4'h8, 1'b0, 1'b1, 3'b100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic ab, input logic bu, input logic mm);
    @(negedge clk); dsp_abort = ab; burst_det = bu; acc_mismatch = mm;
    @(negedge clk); dsp_abort = 1'b0; burst_det = 1'b0; acc_mismatch = 1'b0;
  endtask

  task automatic start_req;
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic timeout_run(input int lim, input string req);
    logic [31:0] d;
    bus_addr = 24'h00_1234;
    start_req();
    repeat (lim - 1) @(negedge clk);
    check({req, " no irq before window"}, 32'(irq_abort), 32'd0);
    @(negedge clk);
    check({req, " irq at window end"}, 32'(irq_abort), 32'd1);
    rd(2'd2, d);
    check("R7 timeout address captured", d, 32'h0000_1234);
    rd(2'd1, d);
    check({req, " timeout flag"}, d, 32'h2);
  endtask

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 irq after reset", 32'(irq_abort), 32'd0);
    rd(2'd0, d); check("R10 control reset", d, 32'h0000_000A);
    rd(2'd1, d); check("R10 flags reset", d, 32'h0);
    rd(2'd2, d); check("R6 debug reset", d, 32'h00FF_FFFF);

    // R7 capture and freeze
    bus_addr = 24'hABCDEF; pulse(1'b0, 1'b1, 1'b0);
    bus_addr = 24'h111111; pulse(1'b0, 1'b0, 1'b1);
    rd(2'd2, d); check("R7 first fault kept", d, 32'h00AB_CDEF);
    rd(2'd1, d); check("R3 burst flag", d, 32'h4);
    bus_addr = 24'h222222; pulse(1'b0, 1'b0, 1'b1);
    check("R7 mismatch no irq", 32'(irq_abort), 32'd0);
    bus_addr = 24'h333333; pulse(1'b1, 1'b0, 1'b0);
    rd(2'd2, d); check("R7 mismatch captured and frozen", d, 32'h0022_2222);
    rd(2'd1, d); check("R1 abort flag with reset enable", d, 32'h1);

    // R9 reserved bit, R4 freq readback
    wr(2'd0, 32'hF);
    rd(2'd0, d); check("R9 reserved bit reads 0 / R4 freq readback", d, 32'hB);

    // vector table: R1 R3 R5
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {28'h0, VEC[i][8:5]});
      bus_addr = 24'(i * 24'h010101);
      pulse(VEC[i][4], VEC[i][3], 1'b0);
      check($sformatf("R5 irq row %0d", i), 32'(irq_abort), 32'(|VEC[i][2:0]));
      rd(2'd1, d);
      check($sformatf("R1/R3 flags row %0d", i), d, 32'(VEC[i][2:0]));
      check($sformatf("R5 irq cleared row %0d", i), 32'(irq_abort), 32'd0);
    end

    // R2 timeout, normal mode
    wr(2'd0, 32'hA);
    timeout_run(TO, "R2");
    // R4 high-frequency mode doubles the window
    wr(2'd0, 32'hB);
    timeout_run(2 * TO, "R4");
    wr(2'd0, 32'hA);

    // R8 acknowledge cancels
    start_req();
    repeat (10) @(negedge clk);
    req_ack = 1'b1; @(negedge clk); req_ack = 1'b0;
    repeat (3 * TO) @(negedge clk);
    check("R8 no timeout after ack", 32'(irq_abort), 32'd0);

    // R2 disabled timeout waits, then fires when enabled
    wr(2'd0, 32'h8);
    start_req();
    repeat (4 * TO) @(negedge clk);
    check("R2 disabled timeout silent", 32'(irq_abort), 32'd0);
    wr(2'd0, 32'hA);
    @(negedge clk);
    check("R2 overdue fires on enable", 32'(irq_abort), 32'd1);
    rd(2'd1, d); check("R2 timeout flag after enable", d, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule